// File: doc/BRIEF.md
# Pseudo-SRAM Mixed-Mode Access Front End

This block is the device-side access controller of a pseudo-static RAM that is configured for synchronous operation. A single address/data bus carries two kinds of traffic. Host reads are clocked bursts, and each one starts when the address strobe is low on a rising bus-clock edge. Host writes are asynchronous random writes, done with the bus clock parked low. The block drives read data and a WAIT flag toward the host. It also issues read and write requests to a small internal word array.

The bus clock (`bus_clk`) is not used as a clock inside the block. It is sampled on a faster system clock (`clk`), and only its sampled rising edges advance a burst. If the host stops the bus clock, high or low, the burst freezes in place. WAIT keeps its level while the burst is frozen. The data pins are released while output enable is high, and the burst resumes with the next word once clocking starts again.

WAIT goes high in three cases: during the initial burst latency, for a fixed penalty when a burst steps into a new row, and while an external refresh flag (`rfsh_busy`) collides with the burst. All inputs are sampled on rising edges of `clk`. A "bus rise" is a `clk` edge at which `bus_clk` is sampled high after being sampled low on the edge before.

Top module: `psram_front`

## Requirements
- R1: A bus rise with `ce_n`=0, `we_n`=1 and `adv_n`=0 starts a burst at `addr`. WAIT is high for the next LAT_CYC (default 3) bus rises. After that, `dq_out` carries the word at `addr`.
- R2: Each bus rise taken while WAIT is low transfers the word on the pins, and the next word comes from address+1. The address wraps from 2^AW-1 to 0.
- R3: When the next address is a multiple of ROW_WORDS (default 128), WAIT rises right after the transfer and stays high for ROW_PEN (default 2) bus rises. The word at the new address follows.
- R4: During latency or row wait, a bus rise with `rfsh_busy`=1 does not count toward the wait. During a transfer, a bus rise with `rfsh_busy`=1 still takes the word, then raises WAIT until a bus rise with `rfsh_busy`=0.
- R5: While no bus rise occurs, the burst position, the word on the pins and the WAIT level all stay unchanged, whether `bus_clk` is held high or low.
- R6: `dq_oe` is 1 only while `ce_n`=0, `oe_n`=0 and a word is presented. Raising `oe_n` during a suspended burst releases the pins. Lowering it drives the same word again.
- R7: An asynchronous write commits at the first `clk` edge where `we_n` is sampled high after being low with `ce_n`=0. It stores the `dq_in` sampled in the last low-`we_n` cycle. The write is dropped if `bus_clk` was sampled high in any low-`we_n` cycle.
- R8: The write address is `addr` from the last low-`we_n` cycle when `adv_n` is low in that cycle (flow-through). Otherwise it is `addr` from the last cycle in which `adv_n` was low (latched on the strobe's rising edge).
- R9: `ce_n`=1 forces WAIT and `dq_oe` low at once and ends the burst; a new burst needs a fresh address strobe. It also cancels a pending write.
- R10: After reset WAIT and `dq_oe` are 0 and every array word reads 0. A write cycle also ends any burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Host burst clock, sampled |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rfsh_busy | input | 1 | Refresh in progress flag from the scheduler |
| addr | input | AW | Word address |
| dq_in | input | DW | Write data from the bus |
| dq_out | output | DW | Read data to the bus |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| wait_o | output | 1 | WAIT flag to the host |

## Verification
A corrupted burst position shows up at the very first transfer after the fault. The host would see a repeated or skipped word, or a row penalty at the wrong address. A wrong wait counter moves the first WAIT-low bus rise earlier or later by whole bus periods. A burst state that is not truly frozen under a halted clock changes `dq_out` or WAIT within the halt window, with no bus rise at all. A mislatched write address or a missed clock-high abort stays hidden until that word is read back by a later burst.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LAT  = 2'd1,
        PH_DATA = 2'd2,
        PH_ROW  = 2'd3
    } phase_e;

    // true when the low rb bits of a word address are all zero
    function automatic logic at_row_start(input logic [31:0] a, input int rb);
        logic [31:0] msk;
        msk = (32'd1 << rb) - 32'd1;
        return (a & msk) == 32'd0;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psram_bus_sampler.sv
module psram_bus_sampler (
    input  logic clk,
    input  logic rst,
    input  logic bus_clk,
    output logic rise
);
    logic bclk_q;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bus_clk;
    end

    assign rise = bus_clk & ~bclk_q;
endmodule

// File: rtl/psram_wr_path.sv
module psram_wr_path #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_clk,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic          wr_act,
    output logic          arr_we,
    output logic [AW-1:0] arr_waddr,
    output logic [DW-1:0] arr_wdata
);
    logic          wr_bad;
    logic [AW-1:0] lat_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_act    <= 1'b0;
            wr_bad    <= 1'b0;
            lat_addr  <= '0;
            arr_waddr <= '0;
            arr_wdata <= '0;
        end else begin
            if (!adv_n) lat_addr <= addr;
            if (ce_n) begin
                wr_act <= 1'b0;
            end else if (!we_n) begin
                wr_act    <= 1'b1;
                wr_bad    <= wr_act ? (wr_bad | bus_clk) : bus_clk;
                arr_wdata <= dq_in;
                arr_waddr <= adv_n ? lat_addr : addr;
            end else begin
                wr_act <= 1'b0;
            end
        end
    end

    assign arr_we = wr_act & we_n & ~ce_n & ~wr_bad;
endmodule

// File: rtl/psram_burst.sv
module psram_burst
    import psram_pkg::*;
#(
    parameter int AW        = 10,
    parameter int LAT_CYC   = 3,
    parameter int ROW_WORDS = 128,
    parameter int ROW_PEN   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          we_n,
    input  logic          wr_act,
    input  logic          rfsh_busy,
    input  logic [AW-1:0] addr,
    output phase_e        phase,
    output logic [AW-1:0] ptr
);
    localparam int RB = $clog2(ROW_WORDS);
    localparam int SW = $clog2(max2(LAT_CYC, ROW_PEN) + 1);

    logic [SW-1:0] stall;
    logic [AW-1:0] ptr_nx;

    assign ptr_nx = ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            ptr   <= '0;
            stall <= '0;
        end else if (ce_n || !we_n || wr_act) begin
            phase <= PH_IDLE;
        end else if (rise) begin
            if (!adv_n) begin
                ptr   <= addr;
                phase <= PH_LAT;
                stall <= SW'(LAT_CYC);
            end else begin
                case (phase)
                    PH_LAT, PH_ROW: begin
                        if (!rfsh_busy) begin
                            if (stall <= SW'(1)) phase <= PH_DATA;
                            else                 stall <= stall - SW'(1);
                        end
                    end
                    PH_DATA: begin
                        ptr <= ptr_nx;
                        if (at_row_start(32'(ptr_nx), RB)) begin
                            phase <= PH_ROW;
                            stall <= SW'(ROW_PEN);
                        end else if (rfsh_busy) begin
                            phase <= PH_LAT;
                            stall <= SW'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/psram_array.sv
module psram_array #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/psram_front.sv
module psram_front
    import psram_pkg::*;
#(
    parameter int AW        = 10,
    parameter int DW        = 16,
    parameter int LAT_CYC   = 3,
    parameter int ROW_WORDS = 128,
    parameter int ROW_PEN   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_clk,
    input  logic          ce_n,
    input  logic          adv_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          rfsh_busy,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic          dq_oe,
    output logic          wait_o
);
    logic          rise;
    logic          wr_act;
    logic          arr_we;
    logic [AW-1:0] arr_waddr;
    logic [DW-1:0] arr_wdata;
    phase_e        phase;
    logic [AW-1:0] ptr;

    psram_bus_sampler u_smp (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .rise(rise)
    );

    psram_wr_path #(.AW(AW), .DW(DW)) u_wr (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .ce_n(ce_n), .adv_n(adv_n),
        .we_n(we_n), .addr(addr), .dq_in(dq_in), .wr_act(wr_act),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    psram_burst #(.AW(AW), .LAT_CYC(LAT_CYC), .ROW_WORDS(ROW_WORDS),
                  .ROW_PEN(ROW_PEN)) u_bst (
        .clk(clk), .rst(rst), .rise(rise), .ce_n(ce_n), .adv_n(adv_n),
        .we_n(we_n), .wr_act(wr_act), .rfsh_busy(rfsh_busy), .addr(addr),
        .phase(phase), .ptr(ptr)
    );

    psram_array #(.AW(AW), .DW(DW)) u_arr (
        .clk(clk), .rst(rst), .we(arr_we), .waddr(arr_waddr),
        .wdata(arr_wdata), .raddr(ptr), .rdata(dq_out)
    );

    assign wait_o = ~ce_n & ((phase == PH_LAT) | (phase == PH_ROW));
    assign dq_oe  = ~ce_n & ~oe_n & (phase == PH_DATA);
endmodule

// File: rtl/psram_front_chk.sv
module psram_front_chk
    import psram_pkg::*;
#(
    parameter int AW        = 10,
    parameter int ROW_WORDS = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_clk,
    input logic          ce_n,
    input logic          adv_n,
    input logic          oe_n,
    input logic          we_n,
    input logic          rise,
    input logic          wr_act,
    input logic          arr_we,
    input phase_e        phase,
    input logic [AW-1:0] ptr,
    input logic          wait_o,
    input logic          dq_oe
);
    localparam int RB = $clog2(ROW_WORDS);

    logic quiet;
    assign quiet = ~rise & ~ce_n & we_n & ~wr_act;

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
        quiet |=> ($stable(phase) && $stable(ptr))); // R5
    AST_WAIT_HELD: assert property (@(posedge clk) disable iff (rst)
        quiet |=> (ce_n || $stable(wait_o))); // R5
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe); // R6
    AST_START_WAITS: assert property (@(posedge clk) disable iff (rst)
        (rise && !adv_n && !ce_n && we_n && !wr_act) |=> (ce_n || wait_o)); // R1
    AST_ROW_PENALTY: assert property (@(posedge clk) disable iff (rst)
        (rise && adv_n && !ce_n && we_n && !wr_act && phase == PH_DATA &&
         ptr[RB-1:0] == {RB{1'b1}}) |=> (ce_n || wait_o)); // R3
    AST_WRITE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> $past(!bus_clk)); // R7
    AST_CE_ENDS: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> phase == PH_IDLE); // R9
endmodule

bind psram_front psram_front_chk #(.AW(AW), .ROW_WORDS(ROW_WORDS)) u_chk (
    .clk(clk), .rst(rst), .bus_clk(bus_clk), .ce_n(ce_n), .adv_n(adv_n),
    .oe_n(oe_n), .we_n(we_n), .rise(rise), .wr_act(wr_act), .arr_we(arr_we),
    .phase(phase), .ptr(ptr), .wait_o(wait_o), .dq_oe(dq_oe)
);

// File: tb/sim_psram_front.sv
`timescale 1ns/1ps
module sim_psram_front;
    localparam int AW = 10;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_clk = 1'b0, ce_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1;
    logic          we_n = 1'b1, rfsh_busy = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe, wait_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    psram_front u0 (
        .clk(clk), .rst(rst), .bus_clk(bus_clk), .ce_n(ce_n), .adv_n(adv_n),
        .oe_n(oe_n), .we_n(we_n), .rfsh_busy(rfsh_busy), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .wait_o(wait_o)
    );

    // ---------------- behavioural reference ----------------
    int m_mem [int];
    int m_ph = 0;            // 0 idle, 1 latency, 2 data, 3 row wait
    int m_ptr = 0, m_cnt = 0;
    bit m_bprev = 0, m_wact = 0, m_wbad = 0;
    int m_lat = 0, m_waddr = 0, m_wdata = 0;

    always @(posedge clk) begin
        bit r, oldw;
        if (rst) begin
            m_mem.delete();
            m_ph = 0; m_ptr = 0; m_cnt = 0; m_bprev = 0;
            m_wact = 0; m_wbad = 0; m_lat = 0; m_waddr = 0; m_wdata = 0;
        end else begin
            r = bus_clk && !m_bprev;
            m_bprev = bus_clk;
            oldw = m_wact;
            if (m_wact && we_n && !ce_n && !m_wbad) m_mem[m_waddr] = m_wdata;
            if (!ce_n && !we_n) begin
                m_wbad  = m_wact ? (m_wbad || bus_clk) : bus_clk;
                m_wact  = 1;
                m_wdata = int'(dq_in);
                m_waddr = adv_n ? m_lat : int'(addr);
            end else m_wact = 0;
            if (!adv_n) m_lat = int'(addr);
            if (ce_n || !we_n || oldw) m_ph = 0;
            else if (r) begin
                if (!adv_n) begin m_ptr = int'(addr); m_ph = 1; m_cnt = 3; end
                else if (m_ph == 1 || m_ph == 3) begin
                    if (!rfsh_busy) begin
                        m_cnt--;
                        if (m_cnt == 0) m_ph = 2;
                    end
                end else if (m_ph == 2) begin
                    m_ptr = (m_ptr + 1) % 1024;
                    if (m_ptr % 128 == 0) begin m_ph = 3; m_cnt = 2; end
                    else if (rfsh_busy) begin m_ph = 1; m_cnt = 1; end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        bit ew, eo;
        int ed;
        if (!rst) begin
            ew = !ce_n && (m_ph == 1 || m_ph == 3);
            eo = !ce_n && !oe_n && m_ph == 2;
            ed = m_mem.exists(m_ptr) ? m_mem[m_ptr] : 0;
            chk(wait_o == ew, {cur_req, " wait"}, int'(wait_o), int'(ew));
            chk(dq_oe == eo, {cur_req, " oe"}, int'(dq_oe), int'(eo));
            if (eo) chk(int'(dq_out) == ed, {cur_req, " data"}, int'(dq_out), ed);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic brise();
        bus_clk = 1'b1; tick(2);
        bus_clk = 1'b0; tick(2);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(a * 3 + 16'h100);
    endfunction

    task automatic wr_flow(input int a, input int d, input bit clk_glitch);
        ce_n = 0; adv_n = 0; addr = AW'(a); dq_in = DW'(d); we_n = 0;
        tick(1);
        if (clk_glitch) bus_clk = 1;
        tick(1);
        bus_clk = 0; we_n = 1; tick(1);
        adv_n = 1; tick(1);
    endtask

    task automatic start(input int a);
        ce_n = 0; adv_n = 0; addr = AW'(a); brise(); adv_n = 1;
    endtask

    task automatic now(input bit ok, input string req, input int act, input int exp);
        #2;
        chk(ok, req, act, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(3); rst = 0; tick(1);
        now(!wait_o && !dq_oe, "R10 reset outputs", {wait_o, dq_oe}, 0);

        cur_req = "R7";
        for (int a = 120; a < 136; a++) wr_flow(a, int'(pat(a)), 0);
        wr_flow(1023, 16'h5A5A, 0);

        // latched address: strobe pulses, address bus then changes
        cur_req = "R8";
        ce_n = 0; adv_n = 0; addr = 10'd200; tick(1);
        adv_n = 1; addr = 10'd77; dq_in = 16'hBEEF; we_n = 0; tick(2);
        we_n = 1; tick(1);
        // flow-through: last low-we_n address wins
        adv_n = 0; addr = 10'd300; dq_in = 16'h0001; we_n = 0; tick(1);
        addr = 10'd202; dq_in = 16'hC0DE; tick(1);
        we_n = 1; tick(1); adv_n = 1; tick(1);
        // write with bus clock high mid-sequence is dropped
        cur_req = "R7";
        wr_flow(201, 16'h1234, 1);
        // chip enable cancels a pending write
        cur_req = "R9";
        adv_n = 0; addr = 10'd210; dq_in = 16'h7777; we_n = 0; tick(1);
        ce_n = 1; tick(1); we_n = 1; tick(1); ce_n = 0; adv_n = 1; tick(1);

        // burst across a row boundary
        cur_req = "R1"; oe_n = 0;
        start(124);
        now(wait_o, "R1 wait after latch", wait_o, 1);
        brise(); brise();
        now(wait_o, "R1 wait in latency", wait_o, 1);
        brise();
        now(dq_oe && dq_out == pat(124), "R1 first word", dq_out, pat(124));
        cur_req = "R2";
        brise(); brise(); brise();
        now(dq_out == pat(127), "R2 increment", dq_out, pat(127));
        cur_req = "R3";
        brise();
        now(wait_o, "R3 row penalty 1", wait_o, 1);
        brise();
        now(wait_o, "R3 row penalty 2", wait_o, 1);
        brise();
        now(!wait_o && dq_out == pat(128), "R3 after penalty", dq_out, pat(128));

        // suspend with bus clock held high, then released
        cur_req = "R5";
        bus_clk = 1; tick(10);
        now(dq_out == pat(129), "R5 halted high", dq_out, pat(129));
        cur_req = "R6";
        oe_n = 1; tick(2);
        now(!dq_oe, "R6 pins released", dq_oe, 0);
        oe_n = 0; bus_clk = 0; tick(6);
        now(dq_oe && dq_out == pat(129), "R6 same word", dq_out, pat(129));
        brise();
        now(dq_out == pat(130), "R6 resume next", dq_out, pat(130));

        // refresh collision during transfer
        cur_req = "R4";
        rfsh_busy = 1; brise();
        now(wait_o, "R4 refresh wait", wait_o, 1);
        brise();
        now(wait_o, "R4 refresh held", wait_o, 1);
        rfsh_busy = 0; brise();
        now(!wait_o && dq_out == pat(131), "R4 after refresh", dq_out, pat(131));

        // chip enable ends the burst
        cur_req = "R9";
        ce_n = 1; tick(1);
        now(!wait_o && !dq_oe, "R9 release", {wait_o, dq_oe}, 0);
        ce_n = 0; tick(1); brise(); brise();
        now(!dq_oe && !wait_o, "R9 stays idle", {wait_o, dq_oe}, 0);

        // refresh and halt during latency
        cur_req = "R4";
        start(120); rfsh_busy = 1; brise(); brise();
        cur_req = "R5";
        tick(12);
        now(wait_o, "R5 wait held low clk", wait_o, 1);
        rfsh_busy = 0; cur_req = "R4";
        brise(); brise();
        now(wait_o, "R4 count held", wait_o, 1);
        brise();
        now(dq_out == pat(120), "R4 latency done", dq_out, pat(120));

        // read back writes
        cur_req = "R8";
        start(200); brise(); brise(); brise();
        now(dq_out == 16'hBEEF, "R8 latched addr", dq_out, 16'hBEEF);
        brise();
        now(dq_out == 16'h0000, "R7 dropped write", dq_out, 0);
        brise();
        now(dq_out == 16'hC0DE, "R8 flow addr", dq_out, 16'hC0DE);
        cur_req = "R9";
        start(210); brise(); brise(); brise();
        now(dq_out == 16'h0000, "R9 write cancelled", dq_out, 0);

        // wrap at top of array
        cur_req = "R2";
        start(1023); brise(); brise(); brise();
        now(dq_out == 16'h5A5A, "R2 top word", dq_out, 16'h5A5A);
        brise();
        now(wait_o, "R3 wrap row wait", wait_o, 1);
        brise(); brise();
        now(dq_oe && dq_out == 16'h0000, "R2 wrap to zero", dq_out, 0);

        // a write ends the burst
        cur_req = "R10";
        wr_flow(5, 16'h0055, 0);
        now(!dq_oe, "R10 write ends burst", dq_oe, 0);

        ce_n = 1; tick(4);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule